// File: doc/BRIEF.md
# Packed-Add Decoder with Fault Screening

This block sits in an instruction decode path. It receives the escape byte and second opcode byte of a candidate packed integer add, a flag that shows whether the width-selecting 66 prefix was seen, and a LOCK flag. It also receives the control state that decides whether the instruction may run. It names the lane size and the operand width. For a recognized opcode it also reports either a clean decode or the single fault that must be raised.

The checks cover these conditions: the emulation and task-switched control bits, OS support for the wide register file, SSE2 presence, a pending x87 exception, and alignment of a memory operand. Several of these checks apply to only one operand width. When more than one check fails, a fixed priority picks the fault to report. Each request is a one-cycle strobe. The result is registered and appears one clock later, together with an output strobe. Between strobes the outputs hold their last value.

Top module: `padd_decode`

## Requirements
- R1: When the escape byte is 0x0F, opcode 0xFC gives lane code 0 (8-bit lanes), 0xFD gives lane code 1 (16-bit), and 0xFE gives lane code 2 (32-bit).
- R2: `wide_op` is 1 (128-bit operands) when `pfx_wide` is set, and 0 (64-bit operands) when it is clear.
- R3: A recognized opcode with `lock_pfx` set or `cr_em` set reports fault code 1 (invalid opcode).
- R4: A 128-bit operation with `cr_osfxsr` clear or `has_sse2` clear reports fault code 1. A 64-bit operation ignores both inputs.
- R5: `cr_ts` set reports fault code 2 (device not available), unless an invalid-opcode condition is present.
- R6: A 64-bit operation with `x87_pend` set reports fault code 3 (math fault). A 128-bit operation ignores `x87_pend`.
- R7: A 128-bit memory operation with `addr_lo` not equal to 0 reports fault code 4 (general protection). A register operand, or a 64-bit operation, never reports code 4.
- R8: A 64-bit memory operation reports fault code 5 (alignment check) when `ac_en` and `cpl3` are both set and `addr_lo[2:0]` is not 0. If any one of these conditions is missing, code 5 is not reported.
- R9: Only one fault is reported. The priority, highest first, is: 1, 2, 3, 4, 5.
- R10: `dec_ok` is 1 only for a recognized opcode with fault code 0. An unrecognized escape or opcode gives `dec_ok` 0 and fault code 0.
- R11: The outputs update on the clock edge that samples `in_valid` high. `out_valid` is high for exactly that following cycle. With `in_valid` low, the other outputs hold.
- R12: While reset is active, and after it is released, `out_valid`, `dec_ok`, `lane_sz`, `wide_op` and `fault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| pfx_wide | input | 1 | 66 prefix present (128-bit operands) |
| esc_byte | input | 8 | First opcode byte |
| op_byte | input | 8 | Second opcode byte |
| lock_pfx | input | 1 | LOCK prefix present |
| cr_em | input | 1 | Emulation control bit |
| cr_ts | input | 1 | Task-switched control bit |
| cr_osfxsr | input | 1 | OS support for wide register save |
| has_sse2 | input | 1 | SSE2 supported |
| x87_pend | input | 1 | Pending x87 exception |
| mem_op | input | 1 | Source is a memory operand |
| addr_lo | input | 4 | Low address bits of the memory operand |
| ac_en | input | 1 | Alignment checking enabled |
| cpl3 | input | 1 | Current privilege level is 3 |
| out_valid | output | 1 | Result strobe |
| dec_ok | output | 1 | Clean decode |
| lane_sz | output | 2 | Lane code |
| wide_op | output | 1 | 128-bit operands |
| fault | output | 3 | Fault code |

## Verification
The assertions assume that the request inputs are stable around the sampling edge, and that `in_valid` is low while reset is asserted or being released. Properties that compare registered outputs with sampled inputs depend on these assumptions. The bench drives every input on the falling edge. It also holds all request inputs at their defaults through reset and for the two synchronizer cycles that follow.

// File: rtl/padd_pkg.sv
package padd_pkg;
  typedef enum logic [1:0] {
    LANE_B8  = 2'd0,
    LANE_H16 = 2'd1,
    LANE_W32 = 2'd2
  } lane_e;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_UD   = 3'd1,
    FLT_NM   = 3'd2,
    FLT_MF   = 3'd3,
    FLT_GP   = 3'd4,
    FLT_AC   = 3'd5
  } fault_e;

  localparam int NUM_FAULTS = 5;
endpackage

// File: rtl/padd_opcode_map.sv
module padd_opcode_map #(
  parameter int          OPW       = 8,
  parameter logic [7:0]  ESC_CODE  = 8'h0F,
  parameter logic [7:0]  OP_BASE   = 8'hFC,
  parameter int          NUM_LANES = 3
) (
  input  logic [OPW-1:0] esc_byte,
  input  logic [OPW-1:0] op_byte,
  output logic           recog,
  output logic [1:0]     lane
);
  logic [NUM_LANES-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_LANES; gi++) begin : g_lane
      localparam logic [OPW-1:0] CODE = OPW'(OP_BASE) + OPW'(gi);
      assign hit[gi] = (op_byte == CODE);
    end
  endgenerate

  always_comb begin
    lane = 2'd0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (hit[i]) lane = 2'(i);
    end
  end

  assign recog = (esc_byte == OPW'(ESC_CODE)) && (|hit);
endmodule

// File: rtl/padd_fault_rank.sv
module padd_fault_rank
  import padd_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int WIDE_ALIGN  = 4,
  parameter int NARROW_ALIGN = 3
) (
  input  logic              wide,
  input  logic              lock_pfx,
  input  logic              cr_em,
  input  logic              cr_ts,
  input  logic              cr_osfxsr,
  input  logic              has_sse2,
  input  logic              x87_pend,
  input  logic              mem_op,
  input  logic [ADDR_W-1:0] addr_lo,
  input  logic              ac_en,
  input  logic              cpl3,
  output fault_e            code
);
  localparam logic [ADDR_W-1:0] WIDE_MASK   = ADDR_W'((1 << WIDE_ALIGN) - 1);
  localparam logic [ADDR_W-1:0] NARROW_MASK = ADDR_W'((1 << NARROW_ALIGN) - 1);

  // cond[k] is the raw condition for fault code k+1
  logic [NUM_FAULTS-1:0] cond;

  always_comb begin
    cond[0] = lock_pfx || cr_em || (wide && (!cr_osfxsr || !has_sse2));
    cond[1] = cr_ts;
    cond[2] = !wide && x87_pend;
    cond[3] = wide && mem_op && ((addr_lo & WIDE_MASK) != '0);
    cond[4] = !wide && mem_op && ac_en && cpl3 && ((addr_lo & NARROW_MASK) != '0);
  end

  // scan from lowest to highest priority so the highest one wins
  always_comb begin
    code = FLT_NONE;
    for (int k = NUM_FAULTS - 1; k >= 0; k--) begin
      if (cond[k]) code = fault_e'(k + 1);
    end
  end

  always_comb begin
    if (lock_pfx) begin
      p_lock_ud_r3: assert (code == FLT_UD);
    end
    if (!wide) begin
      p_narrow_no_gp_r7: assert (code != FLT_GP);
    end
  end
endmodule

// File: rtl/padd_decode.sv
module padd_decode
  import padd_pkg::*;
#(
  parameter int         OPW    = 8,
  parameter int         ADDR_W = 4,
  parameter logic [7:0] ESC    = 8'h0F,
  parameter logic [7:0] OPB    = 8'hFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              pfx_wide,
  input  logic [OPW-1:0]    esc_byte,
  input  logic [OPW-1:0]    op_byte,
  input  logic              lock_pfx,
  input  logic              cr_em,
  input  logic              cr_ts,
  input  logic              cr_osfxsr,
  input  logic              has_sse2,
  input  logic              x87_pend,
  input  logic              mem_op,
  input  logic [ADDR_W-1:0] addr_lo,
  input  logic              ac_en,
  input  logic              cpl3,
  output logic              out_valid,
  output logic              dec_ok,
  output logic [1:0]        lane_sz,
  output logic              wide_op,
  output logic [2:0]        fault
);
  // reset synchronizer: assert asynchronously, release on the clock
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  logic       recog;
  logic [1:0] lane_c;
  fault_e     rank_c;

  padd_opcode_map #(.OPW(OPW), .ESC_CODE(ESC), .OP_BASE(OPB), .NUM_LANES(3)) u_map (
    .esc_byte (esc_byte),
    .op_byte  (op_byte),
    .recog    (recog),
    .lane     (lane_c)
  );

  padd_fault_rank #(.ADDR_W(ADDR_W), .WIDE_ALIGN(4), .NARROW_ALIGN(3)) u_rank (
    .wide      (pfx_wide),
    .lock_pfx  (lock_pfx),
    .cr_em     (cr_em),
    .cr_ts     (cr_ts),
    .cr_osfxsr (cr_osfxsr),
    .has_sse2  (has_sse2),
    .x87_pend  (x87_pend),
    .mem_op    (mem_op),
    .addr_lo   (addr_lo),
    .ac_en     (ac_en),
    .cpl3      (cpl3),
    .code      (rank_c)
  );

  logic       ok_d, wide_d;
  logic [1:0] lane_d;
  logic [2:0] fault_d;

  always_comb begin
    fault_d = recog ? 3'(rank_c) : 3'(FLT_NONE);
    ok_d    = recog && (rank_c == FLT_NONE);
    lane_d  = recog ? lane_c : 2'd0;
    wide_d  = pfx_wide;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid <= 1'b0;
      dec_ok    <= 1'b0;
      lane_sz   <= 2'd0;
      wide_op   <= 1'b0;
      fault     <= 3'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dec_ok  <= ok_d;
        lane_sz <= lane_d;
        wide_op <= wide_d;
        fault   <= fault_d;
      end
    end
  end

  p_strobe_r11: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid);
  p_no_strobe_r11: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> (!out_valid && $stable(fault) && $stable(dec_ok)));
  p_ok_clean_r10: assert property (@(posedge clk) disable iff (!rst_q)
    dec_ok |-> (fault == 3'd0));
  p_unknown_quiet_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && (esc_byte != OPW'(ESC))) |=> (!dec_ok && fault == 3'd0));
  p_ts_nm_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && recog && cr_ts && !lock_pfx && !cr_em && !pfx_wide) |=> (fault == 3'd2));
  p_wide_follows_r2: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> (wide_op == $past(pfx_wide)));
endmodule

// File: tb/sim_padd_decode.sv
`timescale 1ns/1ps
module sim_padd_decode;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, pfx_wide, lock_pfx, cr_em, cr_ts, cr_osfxsr, has_sse2;
  logic x87_pend, mem_op, ac_en, cpl3;
  logic [7:0] esc_byte, op_byte;
  logic [3:0] addr_lo;
  logic out_valid, dec_ok, wide_op;
  logic [1:0] lane_sz;
  logic [2:0] fault;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  padd_decode u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pfx_wide(pfx_wide),
    .esc_byte(esc_byte), .op_byte(op_byte), .lock_pfx(lock_pfx), .cr_em(cr_em),
    .cr_ts(cr_ts), .cr_osfxsr(cr_osfxsr), .has_sse2(has_sse2), .x87_pend(x87_pend),
    .mem_op(mem_op), .addr_lo(addr_lo), .ac_en(ac_en), .cpl3(cpl3),
    .out_valid(out_valid), .dec_ok(dec_ok), .lane_sz(lane_sz), .wide_op(wide_op),
    .fault(fault)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic defaults();
    in_valid = 0; pfx_wide = 0; esc_byte = 8'h0F; op_byte = 8'hFC;
    lock_pfx = 0; cr_em = 0; cr_ts = 0; cr_osfxsr = 1; has_sse2 = 1;
    x87_pend = 0; mem_op = 0; addr_lo = 0; ac_en = 0; cpl3 = 0;
  endtask

  // pulse one request and check the registered result one cycle later
  task automatic fire(input string req, input int e_ok, input int e_lane,
                      input int e_wide, input int e_fault);
    in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk({req, " out_valid"}, out_valid, 1);
    chk({req, " dec_ok"}, dec_ok, e_ok);
    chk({req, " lane"}, lane_sz, e_lane);
    chk({req, " wide"}, wide_op, e_wide);
    chk({req, " fault"}, fault, e_fault);
    defaults();
  endtask

  task automatic t_reset();
    chk("R12 out_valid", out_valid, 0);
    chk("R12 dec_ok", dec_ok, 0);
    chk("R12 lane", lane_sz, 0);
    chk("R12 wide", wide_op, 0);
    chk("R12 fault", fault, 0);
  endtask

  task automatic t_lanes();
    op_byte = 8'hFC; fire("R1 byte", 1, 0, 0, 0);
    op_byte = 8'hFD; fire("R1 half", 1, 1, 0, 0);
    op_byte = 8'hFE; pfx_wide = 1; fire("R1 word R2 wide", 1, 2, 1, 0);
    op_byte = 8'hFD; pfx_wide = 1; fire("R2 wide half", 1, 1, 1, 0);
  endtask

  task automatic t_ud();
    lock_pfx = 1; fire("R3 lock", 0, 0, 0, 1);
    cr_em = 1; pfx_wide = 1; fire("R3 em", 0, 0, 1, 1);
    pfx_wide = 1; cr_osfxsr = 0; fire("R4 osfxsr wide", 0, 0, 1, 1);
    pfx_wide = 1; has_sse2 = 0; fire("R4 sse2 wide", 0, 0, 1, 1);
    cr_osfxsr = 0; has_sse2 = 0; op_byte = 8'hFE; fire("R4 narrow ignores", 1, 2, 0, 0);
  endtask

  task automatic t_nm_mf();
    cr_ts = 1; fire("R5 ts", 0, 0, 0, 2);
    cr_ts = 1; lock_pfx = 1; fire("R5 R9 ud over nm", 0, 0, 0, 1);
    x87_pend = 1; fire("R6 mf narrow", 0, 0, 0, 3);
    x87_pend = 1; pfx_wide = 1; fire("R6 wide ignores", 1, 0, 1, 0);
    x87_pend = 1; cr_ts = 1; fire("R9 nm over mf", 0, 0, 0, 2);
  endtask

  task automatic t_align();
    pfx_wide = 1; mem_op = 1; addr_lo = 4'h8; fire("R7 gp", 0, 0, 1, 4);
    pfx_wide = 1; mem_op = 1; addr_lo = 4'h0; fire("R7 aligned", 1, 0, 1, 0);
    pfx_wide = 1; mem_op = 0; addr_lo = 4'h3; fire("R7 reg operand", 1, 0, 1, 0);
    mem_op = 1; addr_lo = 4'h4; fire("R7 narrow no gp", 1, 0, 0, 0);
    mem_op = 1; addr_lo = 4'h2; ac_en = 1; cpl3 = 1; fire("R8 ac", 0, 0, 0, 5);
    mem_op = 1; addr_lo = 4'h8; ac_en = 1; cpl3 = 1; fire("R8 8-aligned", 1, 0, 0, 0);
    mem_op = 1; addr_lo = 4'h1; ac_en = 1; cpl3 = 0; fire("R8 cpl not 3", 1, 0, 0, 0);
    mem_op = 1; addr_lo = 4'h1; ac_en = 0; cpl3 = 1; fire("R8 ac off", 1, 0, 0, 0);
    mem_op = 1; addr_lo = 4'h1; ac_en = 1; cpl3 = 1; x87_pend = 1; fire("R9 mf over ac", 0, 0, 0, 3);
    pfx_wide = 1; mem_op = 1; addr_lo = 4'h1; cr_ts = 1; fire("R9 nm over gp", 0, 0, 1, 2);
  endtask

  task automatic t_unknown();
    esc_byte = 8'h0E; lock_pfx = 1; fire("R10 bad escape", 0, 0, 0, 0);
    op_byte = 8'hFF; cr_ts = 1; fire("R10 bad opcode", 0, 0, 0, 0);
    op_byte = 8'hFB; fire("R10 below range", 0, 0, 0, 0);
  endtask

  task automatic t_hold();
    cr_ts = 1; op_byte = 8'hFD; fire("R11 setup", 0, 1, 0, 2);
    cr_ts = 0; pfx_wide = 1; op_byte = 8'hFE;
    @(posedge clk);
    @(negedge clk);
    chk("R11 no strobe", out_valid, 0);
    chk("R11 hold fault", fault, 2);
    chk("R11 hold lane", lane_sz, 1);
    chk("R11 hold wide", wide_op, 0);
    defaults();
  endtask

  initial begin
    defaults();
    rst_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_lanes();
    t_ud();
    t_nm_mf();
    t_align();
    t_unknown();
    t_hold();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule